// File: doc/BRIEF.md
# Converter Loopback Pattern Tester

This block runs a go/no-go check on a converter pair wired in a loop. It drives a 7-bit stimulus code toward a digital-to-analog converter. The analog output goes through an analog-to-digital converter, and the code that comes back is presented to the block together with a valid strobe. The block compares the returned code with the code it applied. When the two agree, it moves to the next pattern. When they disagree, it stops, keeps the failing pattern on its output and raises a latched fail flag.

The stimulus follows a twisted-ring (Johnson) sequence that starts at all zeros. At each step the register shifts one place toward the MSB and takes the inverted old MSB into bit 0. The walk ends at the pattern 1111110, which is the ninth pattern. When that pattern compares equal, a pass flag is raised and the stimulus holds. A start strobe begins a new run. Converter settling and the analog path are handled outside this block. The block only gives one dead cycle after each new pattern, and it ignores any sample strobe that arrives in that cycle.

Top module: `loopback_seq_tester`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets `stim` to 0000000 and clears `busy`, `fail` and `done` from that edge on.
- R2: A `start` pulse while `busy` is low (after reset, after a pass or after a fail) sets `stim` to 0000000, sets `busy`, and clears `fail` and `done`, all on the next edge.
- R3: The stimulus order is the twisted ring. The next pattern is `{stim[5:0], ~stim[6]}`, and the run visits nine patterns: 0000000, 0000001, 0000011, 0000111, 0001111, 0011111, 0111111, 1111111, 1111110.
- R4: A pattern is compared only in the waiting cycles that follow its first cycle on `stim`. A `sample_valid` that arrives in that first cycle has no effect on `stim` or on the flags.
- R5: When `sample_valid` is high, `readback` equals `stim`, and `stim` is not 1111110, the next pattern appears on `stim` on the next edge and `busy` stays high.
- R6: When `sample_valid` is high and `readback` equals `stim` = 1111110, `done` rises and `busy` falls on the next edge, and `stim` stays at 1111110.
- R7: When `sample_valid` is high and `readback` differs from `stim` in any bit, `fail` rises and `busy` falls on the next edge, and `stim` stays frozen on the failing pattern.
- R8: After a pass or a fail, `sample_valid` and `readback` have no effect. `stim`, `fail` and `done` hold until `start` or `rst`.
- R9: A `start` pulse while `busy` is high is ignored. `stim` does not reload and the run continues.
- R10: `fail` and `done` are never high together, and neither one is high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle strobe that begins a new run |
| sample_valid | input | 1 | The converter loop has a returned code ready |
| readback | input | 7 | Code returned through the converter loop |
| stim | output | 7 | Registered stimulus code applied to the converter |
| busy | output | 1 | A run is in progress |
| fail | output | 1 | Latched: a returned code did not match |
| done | output | 1 | Latched: the whole sequence matched |

## Verification
The hardest cases to reach are the strobes that arrive in the wrong cycle. These are a sample strobe during the single settle cycle after a new pattern is loaded, and a start strobe in the middle of a run. From the ports both look like ordinary activity, and the only visible evidence is that nothing changes. The bench counts edges from its own start strobe so that it can place each strobe in a chosen cycle. A mismatching code is driven during the settle cycle and the bench checks that `fail` stays low. A start strobe is given both in a waiting cycle and in a settle cycle, and the bench checks that `stim` keeps its pattern.

// File: rtl/lst_pkg.sv
package lst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_APPLY = 3'd1,
    ST_WAIT  = 3'd2,
    ST_PASS  = 3'd3,
    ST_FAIL  = 3'd4
  } lst_state_e;
endpackage

// File: rtl/lst_ring_step.sv
// Twisted-ring successor and last-pattern detect.
module lst_ring_step #(
  parameter int W = 7
) (
  input  logic [W-1:0] pat,
  output logic [W-1:0] nxt,
  output logic         at_last
);
  localparam logic [W-1:0] LAST_PAT = {{(W-1){1'b1}}, 1'b0};

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_head
      assign nxt[i] = ~pat[W-1];
    end else begin : g_body
      assign nxt[i] = pat[i-1];
    end
  end

  assign at_last = (pat == LAST_PAT);
endmodule

// File: rtl/lst_code_cmp.sv
// Bitwise equality of applied and returned codes.
module lst_code_cmp #(
  parameter int W = 7
) (
  input  logic [W-1:0] applied,
  input  logic [W-1:0] returned,
  output logic         same
);
  logic [W-1:0] diff;

  for (genvar i = 0; i < W; i++) begin : g_diff
    assign diff[i] = applied[i] ^ returned[i];
  end

  assign same = ~|diff;
endmodule

// File: rtl/lst_seq_fsm.sv
// Run control: idle, apply (settle), wait for sample, pass, fail.
module lst_seq_fsm
  import lst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       sample_valid,
  input  logic       codes_same,
  input  logic       at_last,
  output lst_state_e state_q,
  output logic       do_load,
  output logic       do_advance,
  output logic       do_pass,
  output logic       do_fail
);
  lst_state_e state_d;

  always_comb begin
    state_d    = state_q;
    do_load    = 1'b0;
    do_advance = 1'b0;
    do_pass    = 1'b0;
    do_fail    = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_PASS, ST_FAIL: begin
        if (start) begin
          do_load = 1'b1;
          state_d = ST_APPLY;
        end
      end
      ST_APPLY: state_d = ST_WAIT;
      ST_WAIT: begin
        if (sample_valid) begin
          if (!codes_same) begin
            do_fail = 1'b1;
            state_d = ST_FAIL;
          end else if (at_last) begin
            do_pass = 1'b1;
            state_d = ST_PASS;
          end else begin
            do_advance = 1'b1;
            state_d    = ST_APPLY;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/loopback_seq_tester.sv
module loopback_seq_tester
  import lst_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         sample_valid,
  input  logic [W-1:0] readback,
  output logic [W-1:0] stim,
  output logic         busy,
  output logic         fail,
  output logic         done
);
  logic [W-1:0] stim_q;
  logic [W-1:0] stim_nxt;
  logic         at_last;
  logic         codes_same;
  logic         busy_q, fail_q, done_q;
  logic         do_load, do_advance, do_pass, do_fail;
  lst_state_e   state_q;

  lst_ring_step #(.W(W)) step_i (
    .pat(stim_q), .nxt(stim_nxt), .at_last(at_last)
  );

  lst_code_cmp #(.W(W)) cmp_i (
    .applied(stim_q), .returned(readback), .same(codes_same)
  );

  lst_seq_fsm fsm_i (
    .clk(clk), .rst(rst), .start(start), .sample_valid(sample_valid),
    .codes_same(codes_same), .at_last(at_last), .state_q(state_q),
    .do_load(do_load), .do_advance(do_advance),
    .do_pass(do_pass), .do_fail(do_fail)
  );

  always_ff @(posedge clk) begin
    if (rst || do_load) stim_q <= '0;
    else if (do_advance) stim_q <= stim_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else if (do_load) begin
      busy_q <= 1'b1;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (do_pass || do_fail) busy_q <= 1'b0;
      if (do_fail) fail_q <= 1'b1;
      if (do_pass) done_q <= 1'b1;
    end
  end

  assign stim = stim_q;
  assign busy = busy_q;
  assign fail = fail_q;
  assign done = done_q;
endmodule

// File: rtl/lst_checker.sv
module lst_checker
  import lst_pkg::*;
#(
  parameter int W = 7
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         sample_valid,
  input logic [W-1:0] readback,
  input logic [W-1:0] stim,
  input logic         busy,
  input logic         fail,
  input logic         done,
  input lst_state_e   st
);
  localparam logic [W-1:0] LAST_PAT = {{(W-1){1'b1}}, 1'b0};

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (stim == '0 && !busy && !fail && !done));

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && stim == '0 && !fail && !done));

  p_settle_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_APPLY) |=> (busy && $stable(stim) && !fail));

  p_step_r3_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && sample_valid && readback == stim && stim != LAST_PAT)
    |=> (busy && stim == {$past(stim[W-2:0]), ~$past(stim[W-1])}));

  p_pass_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && sample_valid && readback == stim && stim == LAST_PAT)
    |=> (done && !busy && $stable(stim)));

  p_fail_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && sample_valid && readback != stim)
    |=> (fail && !busy && $stable(stim)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(stim) && $stable(fail) && $stable(done)));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && start && !sample_valid) |=> (busy && $stable(stim)));

  p_flags_r10: assert property (@(posedge clk) disable iff (rst)
    !(fail && done) && !(busy && (fail || done)));
endmodule

bind loopback_seq_tester lst_checker #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .sample_valid(sample_valid),
  .readback(readback), .stim(stim), .busy(busy), .fail(fail),
  .done(done), .st(state_q)
);

// File: tb/loopback_seq_tester_tb_top.sv
module loopback_seq_tester_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 7;
  localparam int N_PAT = 9;

  typedef struct packed {
    logic [W-1:0] exp_stim;
    logic [W-1:0] err_mask;
  } vec_t;

  localparam vec_t VECS [N_PAT] = '{
    '{7'b0000000, 7'b0}, '{7'b0000001, 7'b0}, '{7'b0000011, 7'b0},
    '{7'b0000111, 7'b0}, '{7'b0001111, 7'b0}, '{7'b0011111, 7'b0},
    '{7'b0111111, 7'b0}, '{7'b1111111, 7'b0}, '{7'b1111110, 7'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sample_valid = 1'b0;
  logic [W-1:0] readback = '0;
  logic [W-1:0] stim;
  logic busy, fail, done;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loopback_seq_tester #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .sample_valid(sample_valid),
    .readback(readback), .stim(stim), .busy(busy), .fail(fail), .done(done)
  );

  task automatic chk(input logic ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [W-1:0] e_stim,
                         input logic e_busy, input logic e_fail, input logic e_done);
    chk(stim == e_stim, {tag, " stim"}, stim, e_stim);
    chk({busy, fail, done} == {e_busy, e_fail, e_done}, {tag, " flags"},
        W'({busy, fail, done}), W'({e_busy, e_fail, e_done}));
  endtask

  // Leaves the bench at the negedge of the settle cycle.
  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic give_sample(input logic [W-1:0] code);
    sample_valid = 1'b1;
    readback = code;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=%b expected=%b", 1'b1, 1'b0);
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_out("R1 reset", '0, 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);

    // Full passing walk (R2, R3, R5, R6)
    pulse_start();
    chk_out("R2 start from idle", '0, 1, 0, 0);
    @(negedge clk);
    for (int i = 0; i < N_PAT; i++) begin
      chk(stim == VECS[i].exp_stim, "R3 pattern order", stim, VECS[i].exp_stim);
      give_sample(VECS[i].exp_stim ^ VECS[i].err_mask);
      if (i < N_PAT - 1) begin
        chk_out("R5 advance", VECS[i+1].exp_stim, 1, 0, 0);
        @(negedge clk);
      end
    end
    chk_out("R6 pass at 1111110", 7'b1111110, 0, 0, 1);

    // R8: samples after pass ignored
    give_sample(7'b0000000);
    @(negedge clk);
    chk_out("R8 hold after pass", 7'b1111110, 0, 0, 1);

    // Restart from pass, then fail at the fourth pattern
    pulse_start();
    chk_out("R2 start from pass", '0, 1, 0, 0);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      give_sample(VECS[i].exp_stim);
      @(negedge clk);
    end
    chk(stim == 7'b0000111, "R3 fourth pattern", stim, 7'b0000111);
    give_sample(7'b0000111 ^ 7'b0000100);
    chk_out("R7 mismatch", 7'b0000111, 0, 1, 0);

    // R8: a matching sample after fail has no effect
    give_sample(7'b0000111);
    @(negedge clk);
    chk_out("R8 hold after fail", 7'b0000111, 0, 1, 0);

    // R2 from fail, and R4: wrong code during the settle cycle is ignored
    pulse_start();
    chk_out("R2 start from fail", '0, 1, 0, 0);
    give_sample(7'b1010101);
    chk_out("R4 settle sample ignored", '0, 1, 0, 0);

    // R9: start during a waiting cycle is ignored
    pulse_start();
    chk_out("R9 start while waiting", '0, 1, 0, 0);
    give_sample(7'b0000000);
    chk_out("R5 advance after R9", 7'b0000001, 1, 0, 0);

    // R9: start during a settle cycle is ignored
    pulse_start();
    chk_out("R9 start while settling", 7'b0000001, 1, 0, 0);

    // R7 with an MSB-only difference
    give_sample(7'b1000001);
    chk_out("R7 msb mismatch", 7'b0000001, 0, 1, 0);

    // R1: reset in the middle of a run
    pulse_start();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_out("R1 reset mid-run", '0, 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_out("R1 idle after reset", '0, 0, 0, 0);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule